// File: doc/BRIEF.md
# Serial Command Port with Display Memory

This block is the host-facing serial slave of a display driver. The host uses three signals plus a return line. It lowers a strobe, shifts bytes in on a shift clock with the least significant bit first, and raises the strobe to close the frame. The first byte of every frame is a command. The commands set the display mode, the display control nibble, the data mode or the byte address. The bytes that follow the command are written into a display memory of 17 words of 24 bits. In a read frame, the bytes that follow instead clock key-scan data back out on an open-drain style return line.

All serial inputs are sampled in the block's own clock domain, which must run well above the shift clock. The display scanner reads whole memory words through a combinational port. The mode and control nibbles are held on output pins for the rest of the driver.

Top module: `serial_disp_port`

## Requirements
- R1: After reset, the display mode and display control outputs are 0, every memory word reads 0, and the return line is released (`sdo_oe` = 0).
- R2: `sdi` is sampled on each rising edge of `sclk` while `stb` is low. Bits form bytes least significant bit first. The first complete byte after the strobe falls is a command, and its opcode is in bits 7:6.
- R3: Opcode 00 loads bits 3:0 of the command into `disp_mode`.
- R4: Opcode 10 loads bits 3:0 of the command into `disp_ctrl`. Neither output changes except at the end of a received byte.
- R5: Opcode 11 loads bits 5:0 as the byte address. A value of 51 to 63 is taken as address 0, and the address never reaches 51.
- R6: Opcode 01 sets the data mode: bit 1 = 1 selects read and 0 selects write, and bit 2 = 1 selects a fixed address. In write mode, every byte after the command in a frame is stored at the byte address. Byte address 3w+k holds bits 8k+7:8k of word w.
- R7: In write mode with auto-increment, the address advances after each stored byte and wraps from 50 to 0. With a fixed address it does not move.
- R8: A data-mode command with bit 1 = 1 captures `key_in` and starts a read. The captured bits leave least significant bit first, one on each falling edge of `sclk`, starting at the first falling edge after the command. `sdo_oe` = 1 pulls the line low for a 0 bit. After all `KEY_BITS` bits the line is released, and no memory write happens in a read frame.
- R9: While `stb` is high, `sclk` is ignored, the bit counter is held at zero and the line is released. A strobe rise in the middle of a byte discards that partial byte.
- R10: `disp_word` returns the addressed 24-bit word, or 0 when `disp_addr` is 17 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| key_in | input | KEY_BITS | Key-scan data captured at a read command |
| sdo_oe | output | 1 | 1 pulls the serial return line low, 0 releases it |
| disp_mode | output | 4 | Display mode nibble |
| disp_ctrl | output | 4 | Display control nibble |
| disp_addr | input | 5 | Word index for the scanner read port |
| disp_word | output | WORD_BITS | Word read from display memory |

## Verification
The hardest state to reach is a strobe rise that lands on a partial byte. The bits already shifted stay in the shift register, so a faulty counter reset would let them complete a bogus command in the next frame. The stimulus sends three bits and then raises the strobe. It then toggles the shift clock several times with the strobe high, and opens a new frame whose command must decode exactly. Address wrap is reached by loading address 49 and writing three bytes. A read frame is checked bit by bit on every falling edge, and again after the 24th bit to confirm that the line is released.

// File: rtl/serial_disp_port.sv
module serial_disp_port #(
  parameter int WORDS     = 17,
  parameter int WORD_BITS = 24,
  parameter int KEY_BITS  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic                 sclk,
  input  logic                 sdi,
  input  logic [KEY_BITS-1:0]  key_in,
  output logic                 sdo_oe,
  output logic [3:0]           disp_mode,
  output logic [3:0]           disp_ctrl,
  input  logic [4:0]           disp_addr,
  output logic [WORD_BITS-1:0] disp_word
);
  localparam int BPW   = WORD_BITS / 8;
  localparam int BYTES = WORDS * BPW;
  localparam int AW    = $clog2(BYTES);
  localparam int KCW   = $clog2(KEY_BITS + 1);

  logic                sclk_q, got_cmd, rd_mode, fixed, rd_act;
  logic [2:0]          bitcnt;
  logic [7:0]          sh;
  logic [AW-1:0]       addr;
  logic [7:0]          mem [BYTES];
  logic [KEY_BITS-1:0] key_sr;
  logic [KCW-1:0]      rd_left;

  wire       rise  = sclk & ~sclk_q & ~stb;
  wire       fall  = ~sclk & sclk_q & ~stb;
  wire [7:0] nbyte = {sdi, sh[7:1]};
  wire       done  = rise && (bitcnt == 3'd7);
  wire [AW-1:0] addr_nx = (addr == AW'(BYTES - 1)) ? '0 : addr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; got_cmd <= 1'b0; rd_mode <= 1'b0; fixed <= 1'b0;
      rd_act <= 1'b0; bitcnt <= '0; sh <= '0; addr <= '0;
      key_sr <= '0; rd_left <= '0; sdo_oe <= 1'b0;
      disp_mode <= '0; disp_ctrl <= '0;
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else begin
      sclk_q <= sclk;
      if (stb) begin
        bitcnt <= '0; got_cmd <= 1'b0; rd_act <= 1'b0; sdo_oe <= 1'b0;
      end else begin
        if (rise) begin
          sh     <= nbyte;
          bitcnt <= bitcnt + 3'd1;
        end
        if (done) begin
          if (!got_cmd) begin
            got_cmd <= 1'b1;
            case (nbyte[7:6])
              2'b00: disp_mode <= nbyte[3:0];
              2'b01: begin
                rd_mode <= nbyte[1];
                fixed   <= nbyte[2];
                if (nbyte[1]) begin
                  rd_act  <= 1'b1;
                  key_sr  <= key_in;
                  rd_left <= KCW'(KEY_BITS);
                end
              end
              2'b10: disp_ctrl <= nbyte[3:0];
              default: addr <= (int'(nbyte[5:0]) < BYTES) ? AW'(nbyte[5:0]) : '0;
            endcase
          end else if (!rd_mode) begin
            mem[addr] <= nbyte;
            if (!fixed) addr <= addr_nx;
          end
        end
        if (fall) begin
          if (rd_act && rd_left != '0) begin
            sdo_oe  <= ~key_sr[0];
            key_sr  <= key_sr >> 1;
            rd_left <= rd_left - 1'b1;
          end else begin
            sdo_oe <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    disp_word = '0;
    if (int'(disp_addr) < WORDS)
      for (int k = 0; k < BPW; k++)
        disp_word[8*k +: 8] = mem[AW'(int'(disp_addr) * BPW + k)];
  end
endmodule

module serial_disp_port_chk #(
  parameter int AW    = 6,
  parameter int BYTES = 51
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stb,
  input logic          sclk,
  input logic          sdo_oe,
  input logic [3:0]    disp_mode,
  input logic [3:0]    disp_ctrl,
  input logic [AW-1:0] addr,
  input logic [2:0]    bitcnt
);
  assert_release_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !sdo_oe);
  assert_counter_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> bitcnt == 3'd0);
  assert_drive_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> ($past(sclk, 2) && !$past(sclk) && !$past(stb)));
  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr) < BYTES);
  assert_ctrl_at_byte_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_ctrl) |-> ($past(bitcnt) == 3'd7 && $past(sclk) && !$past(stb)));
  assert_mode_at_byte_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_mode) |-> ($past(bitcnt) == 3'd7 && $past(sclk) && !$past(stb)));
endmodule

bind serial_disp_port serial_disp_port_chk #(.AW(AW), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(stb), .sclk(sclk), .sdo_oe(sdo_oe),
  .disp_mode(disp_mode), .disp_ctrl(disp_ctrl), .addr(addr), .bitcnt(bitcnt)
);

// File: tb/serial_disp_port_tb.sv
`timescale 1ns/1ps
module serial_disp_port_tb;
  localparam int KB = 24;
  logic clk = 0, rst_n = 0, stb = 1, sclk = 1, sdi = 0;
  logic [KB-1:0] key_in = '0;
  logic [4:0] disp_addr = '0;
  logic sdo_oe;
  logic [3:0] disp_mode, disp_ctrl;
  logic [23:0] disp_word;
  int vecs = 0, fails = 0, cyc = 0;

  serial_disp_port u_dut (.clk(clk), .rst_n(rst_n), .stb(stb), .sclk(sclk), .sdi(sdi),
    .key_in(key_in), .sdo_oe(sdo_oe), .disp_mode(disp_mode), .disp_ctrl(disp_ctrl),
    .disp_addr(disp_addr), .disp_word(disp_word));

  always #5 clk = ~clk;

  logic [7:0] m_mem [51];
  int m_addr = 0, m_bits = 0, m_left = 0;
  bit m_rd = 0, m_fixed = 0, m_first = 1, m_act = 0, m_sdo = 0;
  logic [3:0] m_mode = 0, m_ctrl = 0;
  logic [7:0] m_sh = 0;
  logic [KB-1:0] m_key = 0;

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmp(string tag);
    vecs++;
    if (sdo_oe !== m_sdo) begin fails++; $display("FAIL %s sdo_oe got %0d exp %0d", tag, sdo_oe, m_sdo); end
    vecs++;
    if (disp_mode !== m_mode) begin fails++; $display("FAIL %s disp_mode got %0h exp %0h", tag, disp_mode, m_mode); end
    vecs++;
    if (disp_ctrl !== m_ctrl) begin fails++; $display("FAIL %s disp_ctrl got %0h exp %0h", tag, disp_ctrl, m_ctrl); end
  endtask

  task automatic cmp_mem(string tag);
    for (int w = 0; w < 20; w++) begin
      logic [23:0] e;
      disp_addr = 5'(w);
      #1;
      e = (w < 17) ? {m_mem[3*w+2], m_mem[3*w+1], m_mem[3*w]} : 24'h0;
      vecs++;
      if (disp_word !== e) begin fails++; $display("FAIL %s word %0d got %h exp %h", tag, w, disp_word, e); end
    end
  endtask

  task automatic m_byte(logic [7:0] b);
    if (m_first) begin
      m_first = 0;
      case (b[7:6])
        2'b00: m_mode = b[3:0];
        2'b01: begin m_rd = b[1]; m_fixed = b[2]; if (b[1]) begin m_act = 1; m_key = key_in; m_left = KB; end end
        2'b10: m_ctrl = b[3:0];
        default: m_addr = (b[5:0] > 50) ? 0 : int'(b[5:0]);
      endcase
    end else if (!m_rd) begin
      m_mem[m_addr] = b;
      if (!m_fixed) m_addr = (m_addr == 50) ? 0 : m_addr + 1;
    end
  endtask

  task automatic send_bits(logic [7:0] b, int n, string tag);
    for (int i = 0; i < n; i++) begin
      sclk = 0; sdi = b[i];
      if (m_act && m_left > 0) begin m_sdo = ~m_key[0]; m_key = m_key >> 1; m_left--; end
      else m_sdo = 0;
      hold(4); cmp(tag);
      sclk = 1;
      m_sh = {b[i], m_sh[7:1]};
      m_bits++;
      if (m_bits == 8) begin m_bits = 0; m_byte(m_sh); end
      hold(4); cmp(tag);
    end
  endtask

  task automatic open_frame();
    stb = 0; hold(4);
  endtask

  task automatic close_frame(string tag);
    stb = 1; m_bits = 0; m_first = 1; m_act = 0; m_sdo = 0;
    hold(4); cmp(tag);
  endtask

  task automatic frame(logic [7:0] b [], string tag);
    open_frame();
    foreach (b[i]) send_bits(b[i], 8, tag);
    close_frame(tag);
  endtask

  initial begin
    for (int i = 0; i < 51; i++) m_mem[i] = 0;
    hold(3); rst_n = 1; hold(2);
    cmp("R1"); cmp_mem("R1");

    frame('{8'h40}, "R6");
    begin
      logic [7:0] d [];
      d = new[25];
      d[0] = 8'hC0;
      for (int i = 1; i < 25; i++) d[i] = 8'(i * 37 + 5);
      frame(d, "R6");
    end
    cmp_mem("R6");
    frame('{8'hF1, 8'h11, 8'h22, 8'h33}, "R7");
    cmp_mem("R7");
    frame('{8'h44}, "R7");
    frame('{8'hCA, 8'hAA, 8'hBB, 8'hCC}, "R7");
    cmp_mem("R7");
    frame('{8'h40}, "R6");
    frame('{8'hFF, 8'h5E}, "R5");
    cmp_mem("R5");
    frame('{8'h03}, "R3");
    frame('{8'h8B}, "R4");
    frame('{8'h36, 8'h99}, "R2");
    cmp_mem("R2");

    open_frame();
    send_bits(8'h8F, 3, "R9");
    close_frame("R9");
    for (int i = 0; i < 6; i++) begin sclk = ~sclk; sdi = ~sdi; hold(3); cmp("R9"); end
    sclk = 1; hold(3);
    m_sh = 0;
    frame('{8'h85}, "R9");

    key_in = 24'h5A3C96;
    frame('{8'h42, 8'h00, 8'h00, 8'h00, 8'hFF}, "R8");
    cmp_mem("R8");
    key_in = 24'h0F00F1;
    frame('{8'h42, 8'h12, 8'h34, 8'h56}, "R8");
    frame('{8'h40}, "R6");
    frame('{8'hC3, 8'h01, 8'h02}, "R6");
    cmp_mem("R10");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog got %0d cycles exp fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule